// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Framing

This block turns parallel characters into a serial line frame. A character written by the host first goes into a one-entry holding register. When the shifter is idle, the character moves into the shift register. At that point the holding register is free again, so the host can supply the next character while the current one is still on the wire. Timing comes from an external 16x enable pulse, and every bit on the line lasts sixteen of those pulses.

The frame format is set by configuration inputs:
- the number of data bits,
- an optional even or odd parity bit,
- the length of the stop period.

The format is captured at the moment a character enters the shift register. A separate control forces the line low for as long as it is held. Two flags report progress: one for a free holding register and one for a fully drained transmitter.

Top module: `async_tx_framer`

## Requirements
- R1: Out of reset, and whenever nothing is being sent and break is clear, `txd` is high, and both `hold_empty` and `tx_empty` read 1.
- R2: A frame opens with one low start bit. Every bit lasts exactly 16 clock edges on which `tick16` is 1. Clock edges with `tick16` low do not advance the frame.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits are sent least significant bit first, and write-data bits above the selected length are not sent.
- R4: With `cfg_par_en` set, a parity bit follows the last data bit. When `cfg_par_odd` is 0, the parity makes the count of ones across data and parity even. When `cfg_par_odd` is 1, it makes that count odd. With `cfg_par_en` clear, no parity bit is sent.
- R5: The stop period is high. It lasts 16 ticks when `cfg_stop2` is 0. When `cfg_stop2` is 1, it lasts 24 ticks for 5-bit characters and 32 ticks for 6- to 8-bit characters.
- R6: A write (`wr_en` high) is taken only when `hold_empty` is 1, and `hold_empty` then reads 0 from the next clock. A write made while `hold_empty` is 0 is ignored. `hold_empty` returns to 1 on the clock where the character moves into the shift register, and `txd` goes low on that same clock.
- R7: `tx_empty` is 1 only when both the holding register and the shift register are idle. It rises on the clock that ends the last stop tick.
- R8: While `cfg_break` is 1, `txd` is low whatever the transmitter is doing. Clearing it restores the normal line level.
- R9: A character already waiting in the holding register starts one clock after the previous stop period ends. No extra high ticks appear between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Data length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Long stop period select |
| cfg_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding and shift registers both idle |

## Verification
The flags follow a fixed schedule after a write:
- `hold_empty` falls one clock after the write;
- the transfer into the shifter happens one clock later, when `hold_empty` rises again and `txd` drops for the start bit.

After the transfer, the line advances only on tick edges. The monitor therefore takes one sample per tick, at the falling clock edge just before the rising edge that consumes the tick. It expects exactly sixteen equal samples per bit and an exact number of high stop samples, counted until the next start or until `tx_empty` appears. Flag checks are made at the falling edge that follows the rising edge on which each change is due.

// File: rtl/async_tx_framer.sv
module async_tx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_break,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);

  localparam int unsigned TICKS   = 16;
  localparam logic [4:0]  BIT_END = 5'(TICKS - 1);

  logic [7:0] hold_q;
  logic       hold_full;
  logic [9:0] sh_q;
  logic       busy_q;
  logic       stop_q;
  logic [3:0] bits_left;
  logic [4:0] tcnt;
  logic [4:0] stop_last;

  logic [7:0] mask;
  logic [7:0] masked;
  logic       par_bit;
  logic [9:0] frame;
  logic [3:0] nbits;
  logic [4:0] stop_end;
  logic       load;

  assign load    = !busy_q && hold_full;
  assign mask    = 8'hFF >> (2'd3 - cfg_len);
  assign masked  = hold_q & mask;
  assign par_bit = (^masked) ^ cfg_par_odd;
  assign nbits   = 4'd6 + {2'b00, cfg_len} + {3'b000, cfg_par_en};

  always_comb begin
    frame = {1'b0, masked, 1'b0};
    if (cfg_par_en) frame[4'd6 + {2'b00, cfg_len}] = par_bit;
  end

  always_comb begin
    if (!cfg_stop2)          stop_end = BIT_END;
    else if (cfg_len == 2'd0) stop_end = 5'd23;
    else                     stop_end = 5'd31;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      busy_q    <= 1'b0;
      stop_q    <= 1'b0;
      bits_left <= '0;
      tcnt      <= '0;
      stop_last <= BIT_END;
    end else begin
      if (wr_en && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
      if (load) begin
        sh_q      <= frame;
        busy_q    <= 1'b1;
        stop_q    <= 1'b0;
        tcnt      <= '0;
        bits_left <= nbits;
        stop_last <= stop_end;
        hold_full <= 1'b0;
      end else if (busy_q && tick16) begin
        if (!stop_q) begin
          if (tcnt == BIT_END) begin
            tcnt <= '0;
            sh_q <= sh_q >> 1;
            if (bits_left == 4'd1) stop_q <= 1'b1;
            else                   bits_left <= bits_left - 4'd1;
          end else begin
            tcnt <= tcnt + 5'd1;
          end
        end else if (tcnt == stop_last) begin
          busy_q <= 1'b0;
          stop_q <= 1'b0;
          tcnt   <= '0;
        end else begin
          tcnt <= tcnt + 5'd1;
        end
      end
    end
  end

  assign txd        = cfg_break ? 1'b0 : ((!busy_q || stop_q) ? 1'b1 : sh_q[0]);
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy_q;

endmodule

module async_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic wr_en,
  input logic brk,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty,
  input logic busy
);

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  // R6
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_empty) |=> !hold_empty);

  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> busy);

endmodule

bind async_tx_framer async_tx_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .brk(cfg_break),
  .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .busy(busy_q)
);

// File: tb/async_tx_framer_tb_top.sv
module async_tx_framer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic cfg_stop2 = 1'b0;
  logic cfg_break = 1'b0;
  logic txd, hold_empty, tx_empty;

  typedef struct {
    logic [7:0] data;
    int         len;
    logic       pe;
    logic       po;
    int         stop_ticks;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_off = 1'b0;
  bit   done = 1'b0;

  async_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_break(cfg_break),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #1 tick16 = ~tick16;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] d);
    exp_t e;
    e.data = d;
    e.len  = 5 + int'(cfg_len);
    e.pe   = cfg_par_en;
    e.po   = cfg_par_odd;
    e.stop_ticks = !cfg_stop2 ? 16 : (cfg_len == 2'd0 ? 24 : 32);
    exp_q.push_back(e);
  endtask

  task automatic write_raw(input logic [7:0] d);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    do @(negedge clk); while (!hold_empty);
    push_exp(d);
    write_raw(d);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && exp_q.size() == 0));
    repeat (4) @(negedge clk);
  endtask

  task automatic get_sample(output logic s_txd, output logic s_empty);
    do @(negedge clk); while (!tick16);
    s_txd = txd;
    s_empty = tx_empty;
  endtask

  // Monitor: one sample per consumed tick
  initial begin
    logic s, se;
    bit   have_start;
    have_start = 1'b0;
    forever begin
      if (!have_start) get_sample(s, se);
      have_start = 1'b0;
      if (!done && !mon_off && rst_n && s == 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected frame", 0, 1);
        end else begin
          exp_t e;
          logic [9:0] bits;
          int nb, ok_cnt, hi;
          e = exp_q.pop_front();
          bits = '0;
          for (int i = 0; i < e.len; i++) bits[i+1] = e.data[i];
          nb = 1 + e.len;
          if (e.pe) begin
            logic p;
            p = e.po;
            for (int i = 0; i < e.len; i++) p = p ^ e.data[i];
            bits[nb] = p;
            nb++;
          end
          for (int b = 0; b < nb; b++) begin
            ok_cnt = (b == 0) ? 1 : 0;
            for (int t = (b == 0 ? 1 : 0); t < 16; t++) begin
              get_sample(s, se);
              if (s == bits[b]) ok_cnt++;
            end
            if (b == 0)
              check(ok_cnt == 16, "R2 start bit ticks", ok_cnt, 16);
            else if (e.pe && b == nb - 1)
              check(ok_cnt == 16, "R4 parity bit ticks", ok_cnt, 16);
            else
              check(ok_cnt == 16, "R3 data bit ticks", ok_cnt, 16);
          end
          hi = 0;
          forever begin
            get_sample(s, se);
            if (s == 1'b0 || se) break;
            hi++;
          end
          // R9: when ended by a new start the count must still be exact
          check(hi == e.stop_ticks, "R5 stop ticks", hi, e.stop_ticks);
          if (s == 1'b0) have_start = 1'b1;
          else check(se && hold_empty, "R7 drained flags", int'(hold_empty), 1);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    check(hold_empty == 1'b1, "R1 reset hold_empty", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R1 reset tx_empty", int'(tx_empty), 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 flag timing
    push_exp(8'h3C);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    #0;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    check(hold_empty == 1'b0, "R6 hold_empty after write", int'(hold_empty), 0);
    check(tx_empty == 1'b0, "R7 tx_empty after write", int'(tx_empty), 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R6 hold_empty after transfer", int'(hold_empty), 1);
    check(tx_empty == 1'b0, "R7 tx_empty while shifting", int'(tx_empty), 0);
    check(txd == 1'b0, "R6 start on transfer", int'(txd), 0);
    send(8'hA5);
    write_raw(8'h77);
    @(negedge clk);
    check(hold_empty == 1'b0, "R6 holding still full", int'(hold_empty), 0);
    wait_idle();

    // 8N1 back-to-back
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    send(8'h55); send(8'hA3); send(8'h00); send(8'hFF);
    wait_idle();

    // 5 bits, even parity, long stop (24)
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1;
    send(8'hE5); send(8'h1F); send(8'h00);
    wait_idle();

    // 6 bits, odd parity, long stop (32)
    cfg_len = 2'd1; cfg_par_odd = 1'b1;
    send(8'h2A); send(8'hC0);
    wait_idle();

    // 7 bits, even parity, short stop
    cfg_len = 2'd2; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    send(8'h7E); send(8'h81);
    wait_idle();

    // 5 bits, no parity, short stop
    cfg_len = 2'd0; cfg_par_en = 1'b0;
    send(8'h13);
    wait_idle();

    // R8 break
    mon_off = 1'b1;
    @(posedge clk);
    #1 cfg_break = 1'b1;
    repeat (40) @(negedge clk);
    check(txd == 1'b0, "R8 break holds line low", int'(txd), 0);
    @(posedge clk);
    #1 cfg_break = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R8 line high after break", int'(txd), 1);
    repeat (4) @(negedge clk);
    mon_off = 1'b0;

    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R6 no pending frames", exp_q.size(), 0);
    check(tx_empty == 1'b1, "R7 final tx_empty", int'(tx_empty), 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule